// File: doc/BRIEF.md
# Program ROM Bank Mapper

This block sits between a CPU address bus and a program ROM. It turns CPU addresses from 0x6000 to 0xFFFF into ROM byte addresses. Four 7-bit bank registers and a 3-bit layout selector decide which ROM bank appears in each CPU window. Windows can be 32 KB, 16 KB or 8 KB. In some layouts the top window is locked to the last bank of the ROM. In others a bank register selects it. In two layouts every bank register value is mirrored bit by bit before use.

The CPU programs the block by writing to register addresses. These writes are registered on the clock edge that samples the strobe. The address translation itself is purely combinational from the registered state. It gives a ROM byte address and a select flag. When the select is low, the access falls in unmapped space and the data bus should read zero. The ROM size is set by a parameter. Bank numbers that are too large for the ROM wrap modulo the number of banks of the window size in use.

Top module: `prg_bank_mapper`

## Requirements
- R1: A write (`wr_en` high at a clock edge) whose address ANDed with 0xF007 lies in 0x8000..0x8007 loads bank register number `wr_addr[1:0]` with `wr_data[6:0]`. The new value drives the translation from that edge on. Without a write the registers hold their values.
- R2: A write whose address ANDed with 0xF007 equals 0xD000 sets the layout selector from `wr_data[2:0]` and the low-window read enable from `wr_data[7]`. Writes to any other masked address (for example 0x9000) change nothing.
- R3: CPU addresses below 0x6000 give `rom_sel`=0 and `rom_addr`=0. Addresses 0x6000..0x7FFF give `rom_sel`=1 only while the low-window enable is set. Otherwise they give `rom_sel`=0 and `rom_addr`=0. Addresses 0x8000..0xFFFF always give `rom_sel`=1.
- R4: Layout 0 maps 8 KB bank (4*B3+3) at 0x6000 and the last 32 KB bank at 0x8000..0xFFFF. Layout 4 does the same, except that the 32 KB window uses bank B3.
- R5: Layout 1 maps 8 KB bank (2*B3+1) at 0x6000, 16 KB bank B1 at 0x8000 and the last 16 KB bank at 0xC000. Layout 5 does the same, except that 0xC000 uses 16 KB bank B3.
- R6: Layout 2 maps 8 KB banks B3, B0, B1 and B2 at 0x6000, 0x8000, 0xA000 and 0xC000, and the last 8 KB bank at 0xE000. Layout 6 does the same, except that 0xE000 uses B3.
- R7: Layouts 3 and 7 behave as layouts 2 and 6. The difference is that each register value is first mirrored over 7 bits: bit k moves to bit 6-k, and bit 3 stays in place.
- R8: After reset, bank register k holds k, the layout selector is 0 and the low-window enable is clear.
- R9: A selected access gives `rom_addr` = bank8 * 8192 + `cpu_addr[12:0]`. Here bank8 is the 8 KB bank index reduced modulo 2^(ROM_ADDR_W-13), so bank numbers outside the ROM wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | ROM_ADDR_W | ROM byte address, zero when unselected |
| rom_sel | output | 1 | High when the access hits a ROM window |

## Verification
The hardest case to reach is the mirrored layouts combined with wrap. The mirrored value of a small register is often larger than the ROM's bank count, so the visible bank depends on both the mirroring and the modulo reduction. The stimulus loads bank values whose mirrored form has high bits set, such as 0x21. It then reads every window in layouts 3 and 7 and compares against a model built from byte-address arithmetic. It also reaches the fixed-last-bank windows after loading register values that would be wrong if used by mistake.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int BANK_REG_W = 7;
  localparam int NUM_BANK_REGS = 4;
  localparam int IDX_W = BANK_REG_W + 2;

  typedef logic [BANK_REG_W-1:0] bank_t;
  typedef logic [NUM_BANK_REGS-1:0][BANK_REG_W-1:0] bank_set_t;

  // Mirror a bank number end for end; the centre bit keeps its place.
  function automatic bank_t mirror_bank(bank_t v);
    bank_t r;
    for (int i = 0; i < BANK_REG_W; i++) r[i] = v[BANK_REG_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output bank_set_t   bank_q,
  output logic [2:0]  mode_q,
  output logic        lowen_q
);
  logic [15:0] masked;
  logic        bank_hit;
  logic        ctrl_hit;

  always_comb begin
    masked   = wr_addr & 16'hF007;
    bank_hit = wr_en && (masked[15:3] == 13'h1000);
    ctrl_hit = wr_en && (masked == 16'hD000);
  end

  for (genvar k = 0; k < NUM_BANK_REGS; k++) begin : g_bank
    logic  ce;
    bank_t nxt;
    always_comb begin
      ce  = bank_hit && (wr_addr[1:0] == 2'(k));
      nxt = ce ? wr_data[BANK_REG_W-1:0] : bank_q[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[k] <= BANK_REG_W'(k);
      else        bank_q[k] <= nxt;
    end
  end

  logic [2:0] mode_nxt;
  logic       lowen_nxt;

  always_comb begin
    mode_nxt  = ctrl_hit ? wr_data[2:0] : mode_q;
    lowen_nxt = ctrl_hit ? wr_data[7]   : lowen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 3'd0;
      lowen_q <= 1'b0;
    end else begin
      mode_q  <= mode_nxt;
      lowen_q <= lowen_nxt;
    end
  end
endmodule

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate
  import prg_map_pkg::*;
#(
  parameter int ROM_ADDR_W = 19
) (
  input  logic [15:0]           cpu_addr,
  input  bank_set_t             bank_q,
  input  logic [2:0]            mode_q,
  input  logic                  lowen_q,
  output logic [ROM_ADDR_W-1:0] rom_addr,
  output logic                  rom_sel
);
  localparam int BANK_W = ROM_ADDR_W - 13;

  bank_t            r0, r1, r2, r3;
  logic [1:0]       layout;
  logic             use_reg_top;
  logic             in_low, in_high;
  logic [IDX_W-1:0] idx;

  always_comb begin
    layout      = mode_q[1:0];
    use_reg_top = mode_q[2];
    if (layout == 2'd3) begin
      r0 = mirror_bank(bank_q[0]);
      r1 = mirror_bank(bank_q[1]);
      r2 = mirror_bank(bank_q[2]);
      r3 = mirror_bank(bank_q[3]);
    end else begin
      r0 = bank_q[0];
      r1 = bank_q[1];
      r2 = bank_q[2];
      r3 = bank_q[3];
    end
    in_low  = (cpu_addr[15:13] == 3'b011);
    in_high = cpu_addr[15];
  end

  always_comb begin
    idx = '0;
    if (in_low) begin
      unique case (layout)
        2'd0:    idx = {r3, 2'b11};
        2'd1:    idx = {1'b0, r3, 1'b1};
        default: idx = {2'b00, r3};
      endcase
    end else begin
      unique case (layout)
        2'd0: idx = use_reg_top ? {r3, cpu_addr[14:13]}
                                : {{(IDX_W-2){1'b1}}, cpu_addr[14:13]};
        2'd1: begin
          if (!cpu_addr[14])   idx = {1'b0, r1, cpu_addr[13]};
          else if (use_reg_top) idx = {1'b0, r3, cpu_addr[13]};
          else                 idx = {{(IDX_W-1){1'b1}}, cpu_addr[13]};
        end
        default: begin
          unique case (cpu_addr[14:13])
            2'd0:    idx = {2'b00, r0};
            2'd1:    idx = {2'b00, r1};
            2'd2:    idx = {2'b00, r2};
            default: idx = use_reg_top ? {2'b00, r3} : {IDX_W{1'b1}};
          endcase
        end
      endcase
    end
  end

  always_comb begin
    rom_sel  = in_high || (in_low && lowen_q);
    rom_addr = rom_sel ? {idx[BANK_W-1:0], cpu_addr[12:0]} : '0;
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ROM_ADDR_W = 19  // 15..22: at least one 32 KB bank
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [15:0]           wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [15:0]           cpu_addr,
  output logic [ROM_ADDR_W-1:0] rom_addr,
  output logic                  rom_sel
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  bank_set_t  bank_q;
  logic [2:0] mode_q;
  logic       lowen_q;

  prg_bank_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .bank_q  (bank_q),
    .mode_q  (mode_q),
    .lowen_q (lowen_q)
  );

  prg_bank_xlate #(.ROM_ADDR_W(ROM_ADDR_W)) u_xlate (
    .cpu_addr (cpu_addr),
    .bank_q   (bank_q),
    .mode_q   (mode_q),
    .lowen_q  (lowen_q),
    .rom_addr (rom_addr),
    .rom_sel  (rom_sel)
  );
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk
  import prg_map_pkg::*;
#(
  parameter int ROM_ADDR_W = 19
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [15:0]           wr_addr,
  input logic [7:0]            wr_data,
  input logic [15:0]           cpu_addr,
  input logic [ROM_ADDR_W-1:0] rom_addr,
  input logic                  rom_sel,
  input bank_set_t             bank_q,
  input logic [2:0]            mode_q,
  input logic                  lowen_q
);
  localparam int BANK_W = ROM_ADDR_W - 13;

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr & 16'hF007) >= 16'h8000 && (wr_addr & 16'hF007) <= 16'h8007)
    |=> bank_q[$past(wr_addr[1:0])] == $past(wr_data[6:0]));  // R1

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q) && $stable(mode_q) && $stable(lowen_q));  // R1

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr & 16'hF007) == 16'hD000)
    |=> mode_q == $past(wr_data[2:0]) && lowen_q == $past(wr_data[7]));  // R2

  AST_LOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b011 && !lowen_q) |-> (!rom_sel && rom_addr == '0));  // R3

  AST_BELOW_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> (!rom_sel && rom_addr == '0));  // R3

  AST_HIGH_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> rom_sel);  // R3

  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && cpu_addr[15:13] == 3'b111)
    |-> rom_addr[ROM_ADDR_W-1:13] == {BANK_W{1'b1}});  // R6

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> rom_addr[12:0] == cpu_addr[12:0]);  // R9
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.ROM_ADDR_W(ROM_ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .cpu_addr (cpu_addr),
  .rom_addr (rom_addr),
  .rom_sel  (rom_sel),
  .bank_q   (bank_q),
  .mode_q   (mode_q),
  .lowen_q  (lowen_q)
);

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;
  localparam int AW   = 19;
  localparam int NB8  = 1 << (AW - 13);
  localparam int NB16 = NB8 / 2;
  localparam int NB32 = NB8 / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [15:0]   cpu_addr = '0;
  logic [AW-1:0] rom_addr;
  logic          rom_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mreg[4];
  int mmode;
  bit men;

  always #2 clk = ~clk;  // 250 MHz

  prg_bank_mapper #(.ROM_ADDR_W(AW)) u_prg_bank_mapper (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_addr(cpu_addr), .rom_addr(rom_addr), .rom_sel(rom_sel)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int mirror7(int v);
    int r = 0;
    for (int i = 0; i < 7; i++) if (v[i]) r |= 1 << (6 - i);
    return r;
  endfunction

  // Expected byte address, or -1 when the access is unmapped.
  function automatic int ref_map(int a);
    int r[4];
    int lay = mmode & 3;
    bit top_reg = (mmode & 4) != 0;
    for (int k = 0; k < 4; k++) r[k] = (lay == 3) ? mirror7(mreg[k]) : mreg[k];
    if (a < 'h6000) return -1;
    if (a < 'h8000) begin
      if (!men) return -1;
      case (lay)
        0: return ((r[3] * 4 + 3) % NB8) * 8192 + (a & 'h1FFF);
        1: return ((r[3] * 2 + 1) % NB8) * 8192 + (a & 'h1FFF);
        default: return (r[3] % NB8) * 8192 + (a & 'h1FFF);
      endcase
    end
    case (lay)
      0: return (top_reg ? r[3] % NB32 : NB32 - 1) * 32768 + (a - 'h8000);
      1: begin
        if (a < 'hC000) return (r[1] % NB16) * 16384 + (a & 'h3FFF);
        return (top_reg ? r[3] % NB16 : NB16 - 1) * 16384 + (a & 'h3FFF);
      end
      default: begin
        int slot = (a >> 13) & 3;
        int b = (slot == 3) ? (top_reg ? r[3] : NB8 - 1) : r[slot];
        return (b % NB8) * 8192 + (a & 'h1FFF);
      end
    endcase
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (((a & 'hF007) >= 'h8000) && ((a & 'hF007) <= 'h8007)) mreg[a & 3] = d & 'h7F;
    if ((a & 'hF007) == 'hD000) begin mmode = d & 7; men = (d & 'h80) != 0; end
  endtask

  task automatic probe(string tag, int a);
    int e;
    @(negedge clk);
    cpu_addr = 16'(a);
    #1;
    e = ref_map(a);
    if (e < 0) begin
      chk(tag, 32'(rom_sel), 32'd0);
      chk(tag, 32'(rom_addr), 32'd0);
    end else begin
      chk(tag, 32'(rom_sel), 32'd1);
      chk(tag, 32'(rom_addr), 32'(e));
    end
  endtask

  task automatic sweep(string tag);
    int pts[8] = '{'h6000, 'h7FFF, 'h8000, 'h9ABC, 'hA123, 'hC000, 'hE456, 'hFFFF};
    foreach (pts[i]) probe(tag, pts[i]);
  endtask

  task automatic t_reset;  // R8
    mreg = '{0, 1, 2, 3}; mmode = 0; men = 0;
    probe("R8 reset low window gated", 'h6000);
    probe("R8 reset last 32K", 'h8000);
    wr('hD000, 'h82);
    sweep("R8 reset bank values in layout 2");
  endtask

  task automatic t_bank_load;  // R1
    wr('h8000, 'h05); wr('h8001, 'h8A); wr('h8002, 'h13); wr('h8007, 'h21);
    sweep("R1 bank load incl. mirror address 0x8007 and bit7 drop");
  endtask

  task automatic t_ignore;  // R2
    wr('h9000, 'h87); wr('hD001, 'h05); wr('hC003, 'hFF);
    sweep("R2 non-register writes ignored");
    wr('hD008, 'h84);  // masks to 0xD000
    sweep("R2 control write via mirrored address");
  endtask

  task automatic t_gate;  // R3
    wr('hD000, 'h02);
    probe("R3 low window gated", 'h6000);
    probe("R3 low window gated top", 'h7FFF);
    probe("R3 below window", 'h5FFF);
    probe("R3 zero page", 'h0000);
    probe("R3 high window still mapped", 'h8000);
    wr('hD000, 'h82);
    probe("R3 low window enabled", 'h6010);
    probe("R3 below window stays unmapped", 'h4020);
  endtask

  task automatic t_layouts;  // R4 R5 R6 R7
    wr('h8000, 'h05); wr('h8001, 'h0A); wr('h8002, 'h13); wr('h8003, 'h21);
    wr('hD000, 'h80); sweep("R4 layout 0");
    wr('hD000, 'h84); sweep("R4 layout 4");
    wr('hD000, 'h81); sweep("R5 layout 1");
    wr('hD000, 'h85); sweep("R5 layout 5");
    wr('hD000, 'h82); sweep("R6 layout 2");
    wr('hD000, 'h86); sweep("R6 layout 6");
    wr('hD000, 'h83); sweep("R7 layout 3");
    wr('hD000, 'h87); sweep("R7 layout 7");
    wr('h8000, 'h01); wr('h8003, 'h08);
    probe("R7 mirror bit0 to bit6", 'h8000);
    probe("R7 centre bit kept", 'hE000);
  endtask

  task automatic t_wrap;  // R9
    wr('h8000, 'h50); wr('h8001, 'h7F); wr('h8003, 'h7E);
    wr('hD000, 'h86); sweep("R9 wrap 8K banks");
    wr('hD000, 'h85); sweep("R9 wrap 16K banks");
    wr('hD000, 'h84); sweep("R9 wrap 32K banks");
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bank_load();
    t_ignore();
    t_gate();
    t_layouts();
    t_wrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule